// File: doc/BRIEF.md
# Eight-Channel Timer Register Front End

This block is the memory-mapped register front end for a bank of eight timer channels. It takes one 32-bit word request per cycle, decodes the offset, and either serves one of two shared registers itself or passes the access to a channel port. The two shared registers are a control word and an auxiliary word. Channel accesses go out as per-channel write strobes with a register index and data. Read data comes back on per-channel input buses. The counters themselves sit outside this block.

The control word gives each channel a four-bit field. When the control word is written, the block works out, channel by channel, what changed. It then drives the channel-side settings in a fixed order. A channel being switched off loses its run level in the same cycle that its new configuration is applied. A channel being switched on receives its run level and enable strobe one cycle after its configuration. The request interface is valid/ready. The block holds `req_ready` low for that one extra cycle, so no access can slip in between the two steps. Each accepted request produces exactly one response cycle on `rsp_valid`, one cycle later. The response side has no back-pressure, so the requester must always be able to take it.

Top module: `tmr_regbank`

## Requirements
- R1: After reset, the control and auxiliary words read as zero. All channel run levels, settings and strobes are low, `req_ready` is high and `rsp_valid` is low.
- R2: A legal word write to offsets 0x00–0x2F targets channel `offset[7:4]` (0–2) at register `offset[3:2]`. In the cycle after acceptance, exactly that bit of `ch_wr_stb` is high, with `ch_wr_idx` and `ch_wdata` carrying the index and data.
- R3: Offsets 0x40–0x8F target channel `offset[7:4] - 1` (3–7), with the same register index and write behaviour as R2.
- R4: A read of a channel offset returns that channel's `ch_rdata` word on `rsp_rdata`. The word is sampled while the request is accepted, and `ch_sel_idx` equals `req_addr[3:2]` during that cycle.
- R5: The control word at 0x30 and the auxiliary word at 0x34 store all 32 written bits and read back what was written.
- R6: Offsets 0x38, 0x3C, 0x90–0xFF and any address with a nonzero bit above bit 7 are illegal. Reads there return zero, writes change no register and raise no strobe, and `acc_err` is high for the one response cycle.
- R7: An access whose `req_be` is not 4'b1111, or whose `req_addr[1:0]` is not zero, is illegal and is handled as in R6.
- R8: Channel c owns control bits 4c..4c+3: run enable (bit 4c), external clock select (4c+1), overflow interrupt enable (4c+2) and pulse enable (4c+3). In the cycle after a control write is accepted, `ch_ext_clk`, `ch_ovf_irq` and `ch_pulse` show the new settings.
- R9: A channel whose enable bit goes from 1 to 0 has `ch_dis_stb` high and `ch_en` low in the cycle after acceptance, the same cycle its configuration is applied.
- R10: A channel whose enable bit goes from 0 to 1 keeps `ch_en` low in the cycle after acceptance. In the next cycle `ch_en_stb` pulses and `ch_en` rises. `req_ready` is low in between, and `ch_en_stb` never coincides with `ch_cfg_stb` on a channel.
- R11: `ch_cfg_stb` pulses for channel c only when its clock select or interrupt enable bit changed, or, for channels 4–7, its pulse enable bit changed. A control write that changes nothing raises no strobe.
- R12: On channels 0–3 the pulse enable bit has no effect. `ch_pulse` stays low and no configuration strobe fires for it. When a control write flips that bit, `pulse_err` pulses for one cycle. The stored control word still reads back the written bit.
- R13: `rsp_valid` is high exactly in the cycle after each accepted request. For writes, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken; low while a channel enable is pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response cycle, one per accepted request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and illegal reads |
| acc_err | output | 1 | Illegal access, valid with rsp_valid |
| ch_sel_idx | output | 2 | Register index of the current request, for channel read muxes |
| ch_rdata | input | N_CH*DATA_W | Per-channel read words, channel c at bits c*DATA_W |
| ch_wr_stb | output | N_CH | Per-channel register write strobe |
| ch_wr_idx | output | 2 | Register index of the write |
| ch_wdata | output | DATA_W | Write data to the channel |
| ch_en | output | N_CH | Applied run level per channel |
| ch_ext_clk | output | N_CH | Applied external clock select |
| ch_ovf_irq | output | N_CH | Applied overflow interrupt enable |
| ch_pulse | output | N_CH | Applied pulse enable (channels 4–7 only) |
| ch_dis_stb | output | N_CH | Disable strobe |
| ch_cfg_stb | output | N_CH | Configuration change strobe |
| ch_en_stb | output | N_CH | Enable strobe, one cycle after configuration |
| pulse_err | output | 1 | Pulse bit changed on a channel that cannot pulse |

## Verification
The bench builds the block with its default parameters: eight channels, pulse support from channel 4, and a 12-bit offset. At these values the whole low byte of the offset space can be swept word by word for both reads and writes. That sweep covers both halves of the split channel map, the two shared registers, the holes between and after them, and an address with an upper bit set. The control sequencing is driven with word patterns that turn every channel on, off, and reconfigured at once. The bench computes the expected strobes field by field, which reaches both the pulse-capable and the non-pulse channel groups.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_EXT = 1;
  localparam int unsigned BIT_OVF = 2;
  localparam int unsigned BIT_PUL = 3;
  localparam int unsigned LOW_SLOTS = 3;   // channels mapped below the control words

  typedef enum logic [1:0] {
    TGT_CHAN = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_AUX  = 2'd2,
    TGT_BAD  = 2'd3
  } tgt_e;
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
  import tmr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_CH   = 8,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output tgt_e              tgt,
  output logic [CH_W-1:0]   ch,
  output logic [1:0]        reg_idx
);
  localparam int unsigned HIGH_BASE = 'h40;
  localparam int unsigned HIGH_END  = HIGH_BASE + (N_CH - LOW_SLOTS) * 16;

  logic [7:0] off;
  logic       upper_zero;
  logic       aligned;

  assign off        = addr[7:0];
  assign upper_zero = (addr[ADDR_W-1:8] == '0);
  assign aligned    = (be == 4'b1111) && (addr[1:0] == 2'b00);
  assign reg_idx    = addr[3:2];

  always_comb begin
    tgt = TGT_BAD;
    ch  = '0;
    if (aligned && upper_zero) begin
      if (off < 8'h30) begin
        tgt = TGT_CHAN;
        ch  = CH_W'(off[7:4]);
      end else if (off == 8'h30) begin
        tgt = TGT_CTRL;
      end else if (off == 8'h34) begin
        tgt = TGT_AUX;
      end else if ((int'(off) >= HIGH_BASE) && (int'(off) < HIGH_END)) begin
        tgt = TGT_CHAN;
        ch  = CH_W'(off[7:4] - 4'd1);
      end
    end
  end

  // R3: a channel hit never names a channel beyond the bank
  always_comb begin
    p_chan_in_range_r3: assert ((tgt != TGT_CHAN) || (int'(ch) < N_CH))
      else $error("decoded channel out of range");
  end
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_bank_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned PULSE_FIRST = 4,
  localparam int unsigned CTRL_W     = FIELD_W * N_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              busy,
  output logic [N_CH-1:0]   ch_en,
  output logic [N_CH-1:0]   ch_ext,
  output logic [N_CH-1:0]   ch_ovf,
  output logic [N_CH-1:0]   ch_pulse,
  output logic [N_CH-1:0]   dis_stb,
  output logic [N_CH-1:0]   cfg_stb,
  output logic [N_CH-1:0]   en_stb,
  output logic              pulse_err
);
  logic [N_CH-1:0] dis_n, pend_n, cfg_n, perr_n, ext_n, ovf_n, pul_n;
  logic [N_CH-1:0] pend_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_field
    logic [FIELD_W-1:0] o_f, n_f, diff;
    assign o_f       = ctrl_q[c*FIELD_W +: FIELD_W];
    assign n_f       = wdata[c*FIELD_W +: FIELD_W];
    assign diff      = o_f ^ n_f;
    assign dis_n[c]  = o_f[BIT_EN] & ~n_f[BIT_EN];
    assign pend_n[c] = ~o_f[BIT_EN] & n_f[BIT_EN];
    assign ext_n[c]  = n_f[BIT_EXT];
    assign ovf_n[c]  = n_f[BIT_OVF];
    if (c >= PULSE_FIRST) begin : g_pulse
      assign cfg_n[c]  = diff[BIT_EXT] | diff[BIT_OVF] | diff[BIT_PUL];
      assign pul_n[c]  = n_f[BIT_PUL];
      assign perr_n[c] = 1'b0;
    end else begin : g_nopulse
      assign cfg_n[c]  = diff[BIT_EXT] | diff[BIT_OVF];
      assign pul_n[c]  = 1'b0;
      assign perr_n[c] = diff[BIT_PUL];
    end
  end

  assign busy = |pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      pend_q    <= '0;
      ch_en     <= '0;
      ch_ext    <= '0;
      ch_ovf    <= '0;
      ch_pulse  <= '0;
      dis_stb   <= '0;
      cfg_stb   <= '0;
      en_stb    <= '0;
      pulse_err <= 1'b0;
    end else begin
      dis_stb   <= '0;
      cfg_stb   <= '0;
      en_stb    <= '0;
      pulse_err <= 1'b0;
      if (|pend_q) begin
        en_stb <= pend_q;
        ch_en  <= ch_en | pend_q;
        pend_q <= '0;
      end else if (wr_en) begin
        ctrl_q    <= wdata;
        dis_stb   <= dis_n;
        cfg_stb   <= cfg_n;
        pend_q    <= pend_n;
        ch_en     <= ch_en & ~dis_n;
        ch_ext    <= ext_n;
        ch_ovf    <= ovf_n;
        ch_pulse  <= pul_n;
        pulse_err <= |perr_n;
      end
    end
  end

  // R10: enable and configuration strobes never share a cycle on one channel
  p_en_after_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb & cfg_stb) == '0);

  // R10: a run level only rises together with its enable strobe
  p_en_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_en & ~$past(ch_en)) & ~en_stb) == '0);

  // R9: a disabled channel is already stopped when its strobe is seen
  p_dis_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_stb & ch_en) == '0);
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [CH_W-1:0]        ch,
  input  logic [1:0]             idx,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [N_CH*DATA_W-1:0] ch_rdata,
  output logic [N_CH-1:0]        ch_wr_stb,
  output logic [1:0]             ch_wr_idx,
  output logic [DATA_W-1:0]      ch_wdata,
  output logic [DATA_W-1:0]      rd_word
);
  logic [N_CH-1:0] sel_1h;

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign sel_1h[c] = (int'(ch) == c);
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (sel_1h[c]) rd_word = ch_rdata[c*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_wr_stb <= '0;
      ch_wr_idx <= '0;
      ch_wdata  <= '0;
    end else begin
      ch_wr_stb <= wr ? sel_1h : '0;
      if (wr) begin
        ch_wr_idx <= idx;
        ch_wdata  <= wdata;
      end
    end
  end

  // R2: at most one channel is written per cycle
  p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_stb));
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned N_CH        = 8,
  parameter int unsigned PULSE_FIRST = 4,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [3:0]             req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   acc_err,
  output logic [1:0]             ch_sel_idx,
  input  logic [N_CH*DATA_W-1:0] ch_rdata,
  output logic [N_CH-1:0]        ch_wr_stb,
  output logic [1:0]             ch_wr_idx,
  output logic [DATA_W-1:0]      ch_wdata,
  output logic [N_CH-1:0]        ch_en,
  output logic [N_CH-1:0]        ch_ext_clk,
  output logic [N_CH-1:0]        ch_ovf_irq,
  output logic [N_CH-1:0]        ch_pulse,
  output logic [N_CH-1:0]        ch_dis_stb,
  output logic [N_CH-1:0]        ch_cfg_stb,
  output logic [N_CH-1:0]        ch_en_stb,
  output logic                   pulse_err
);
  localparam int unsigned CH_W   = $clog2(N_CH);
  localparam int unsigned CTRL_W = FIELD_W * N_CH;

  tgt_e              tgt;
  logic [CH_W-1:0]   dec_ch;
  logic [1:0]        dec_idx;
  logic              accept, busy;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] aux_q, chan_word, rd_sel;

  assign accept     = req_valid && req_ready;
  assign req_ready  = !busy;
  assign ch_sel_idx = dec_idx;

  tmr_addr_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
    .addr(req_addr), .be(req_be), .tgt(tgt), .ch(dec_ch), .reg_idx(dec_idx)
  );

  tmr_ctrl_seq #(.N_CH(N_CH), .PULSE_FIRST(PULSE_FIRST)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && req_write && (tgt == TGT_CTRL)),
    .wdata(req_wdata[CTRL_W-1:0]),
    .ctrl_q(ctrl_q), .busy(busy),
    .ch_en(ch_en), .ch_ext(ch_ext_clk), .ch_ovf(ch_ovf_irq), .ch_pulse(ch_pulse),
    .dis_stb(ch_dis_stb), .cfg_stb(ch_cfg_stb), .en_stb(ch_en_stb),
    .pulse_err(pulse_err)
  );

  tmr_chan_port #(.N_CH(N_CH), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .wr(accept && req_write && (tgt == TGT_CHAN)),
    .ch(dec_ch), .idx(dec_idx), .wdata(req_wdata), .ch_rdata(ch_rdata),
    .ch_wr_stb(ch_wr_stb), .ch_wr_idx(ch_wr_idx), .ch_wdata(ch_wdata),
    .rd_word(chan_word)
  );

  always_comb begin
    unique case (tgt)
      TGT_CHAN: rd_sel = chan_word;
      TGT_CTRL: rd_sel = DATA_W'(ctrl_q);
      TGT_AUX:  rd_sel = aux_q;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_rdata <= (accept && !req_write) ? rd_sel : '0;
      acc_err   <= accept && (tgt == TGT_BAD);
      if (accept && req_write && (tgt == TGT_AUX)) aux_q <= req_wdata;
    end
  end

  // R13: every response answers a request accepted the cycle before
  p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  // R10: a stalled cycle is always followed by an enable strobe
  p_stall_then_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (|ch_en_stb));

  // R6: an error response never comes with a channel write
  p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (ch_wr_stb == '0));
endmodule

// File: tb/tmr_regbank_tb.sv
`timescale 1ns/1ps
module tmr_regbank_tb;
  localparam int N = 8;
  localparam int PF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, acc_err, pulse_err;
  logic [31:0] rsp_rdata, ch_wdata;
  logic [1:0]  ch_sel_idx, ch_wr_idx;
  logic [N*32-1:0] ch_rdata;
  logic [N-1:0] ch_wr_stb, ch_en, ch_ext_clk, ch_ovf_irq, ch_pulse;
  logic [N-1:0] ch_dis_stb, ch_cfg_stb, ch_en_stb;

  int checks = 0, errors = 0;
  logic [31:0] m_ctrl = '0, m_aux = '0;

  always #10 clk = ~clk;

  for (genvar c = 0; c < N; c++) begin : g_rd
    assign ch_rdata[c*32 +: 32] = {8'hC3, 8'(c), 14'h0, ch_sel_idx};
  end

  tmr_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .acc_err(acc_err),
    .ch_sel_idx(ch_sel_idx), .ch_rdata(ch_rdata), .ch_wr_stb(ch_wr_stb),
    .ch_wr_idx(ch_wr_idx), .ch_wdata(ch_wdata), .ch_en(ch_en), .ch_ext_clk(ch_ext_clk),
    .ch_ovf_irq(ch_ovf_irq), .ch_pulse(ch_pulse), .ch_dis_stb(ch_dis_stb),
    .ch_cfg_stb(ch_cfg_stb), .ch_en_stb(ch_en_stb), .pulse_err(pulse_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one request from a negedge; return at the negedge after acceptance
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) begin @(posedge clk); @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  // expected target: 0 chan, 1 ctrl, 2 aux, 3 illegal
  function automatic int kind(input logic [11:0] a, input logic [3:0] be, output int ch);
    int o = int'(a[7:0]);
    ch = 0;
    if (be != 4'hF || a[1:0] != 0 || a[11:8] != 0) return 3;
    if (o < 'h30) begin ch = o / 16; return 0; end
    if (o == 'h30) return 1;
    if (o == 'h34) return 2;
    if (o >= 'h40 && o < 'h90) begin ch = o / 16 - 1; return 0; end
    return 3;
  endfunction

  task automatic do_read(input logic [11:0] a, input logic [3:0] be);
    int ch, k;
    logic [31:0] exp;
    k = kind(a, be, ch);
    access(1'b0, a, 32'h0, be);
    case (k)
      0: exp = {8'hC3, 8'(ch), 14'h0, a[3:2]};
      1: exp = m_ctrl;
      2: exp = m_aux;
      default: exp = 32'h0;
    endcase
    chk($sformatf("R4/R5/R6 read data @%h", a), rsp_rdata, exp);
    chk($sformatf("R13 rsp_valid read @%h", a), {31'b0, rsp_valid}, 32'd1);
    chk($sformatf("R6/R7 acc_err read @%h", a), {31'b0, acc_err}, {31'b0, k == 3});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    int ch, k;
    k = kind(a, be, ch);
    access(1'b1, a, d, be);
    if (k == 2) m_aux = d;
    chk($sformatf("R13 write rdata @%h", a), rsp_rdata, 32'h0);
    chk($sformatf("R6/R7 acc_err write @%h", a), {31'b0, acc_err}, {31'b0, k == 3});
    if (k == 0) begin
      chk($sformatf("R2/R3 wr_stb @%h", a), {24'b0, ch_wr_stb}, 32'd1 << ch);
      chk($sformatf("R2 wr_idx @%h", a), {30'b0, ch_wr_idx}, {30'b0, a[3:2]});
      chk($sformatf("R2 wdata @%h", a), ch_wdata, d);
    end else begin
      chk($sformatf("R6 no wr_stb @%h", a), {24'b0, ch_wr_stb}, 32'h0);
    end
  endtask

  task automatic ctrl_test(input logic [31:0] nv);
    logic [N-1:0] e_dis, e_cfg, e_pend, e_en1, e_en2, e_ext, e_ovf, e_pul;
    logic e_perr;
    e_perr = 1'b0;
    for (int c = 0; c < N; c++) begin
      logic [3:0] o, n;
      o = m_ctrl[4*c +: 4]; n = nv[4*c +: 4];
      e_dis[c]  = o[0] & ~n[0];
      e_pend[c] = ~o[0] & n[0];
      e_en1[c]  = o[0] & n[0];
      e_en2[c]  = n[0];
      e_ext[c]  = n[1];
      e_ovf[c]  = n[2];
      e_pul[c]  = (c >= PF) ? n[3] : 1'b0;
      e_cfg[c]  = (o[1] ^ n[1]) | (o[2] ^ n[2]) | ((c >= PF) & (o[3] ^ n[3]));
      if (c < PF && (o[3] ^ n[3])) e_perr = 1'b1;
    end
    access(1'b1, 12'h030, nv, 4'hF);
    chk("R9 dis_stb", {24'b0, ch_dis_stb}, {24'b0, e_dis});
    chk("R11 cfg_stb", {24'b0, ch_cfg_stb}, {24'b0, e_cfg});
    chk("R10 no en_stb in config cycle", {24'b0, ch_en_stb}, 32'h0);
    chk("R9/R10 ch_en after config", {24'b0, ch_en}, {24'b0, e_en1});
    chk("R8 ext_clk", {24'b0, ch_ext_clk}, {24'b0, e_ext});
    chk("R8 ovf_irq", {24'b0, ch_ovf_irq}, {24'b0, e_ovf});
    chk("R8/R12 pulse", {24'b0, ch_pulse}, {24'b0, e_pul});
    chk("R12 pulse_err", {31'b0, pulse_err}, {31'b0, e_perr});
    chk("R10 ready in config cycle", {31'b0, req_ready}, {31'b0, e_pend == '0});
    @(posedge clk); @(negedge clk);
    chk("R10 en_stb", {24'b0, ch_en_stb}, {24'b0, e_pend});
    chk("R10 ch_en final", {24'b0, ch_en}, {24'b0, e_en2});
    chk("R10 no cfg with en", {24'b0, ch_cfg_stb}, 32'h0);
    chk("R12 pulse_err one cycle", {31'b0, pulse_err}, 32'h0);
    chk("R10 ready after", {31'b0, req_ready}, 32'd1);
    m_ctrl = nv;
    do_read(12'h030, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 ch_en", {24'b0, ch_en}, 32'd0);
    chk("R1 settings", {8'b0, ch_ext_clk, ch_ovf_irq, ch_pulse}, 32'd0);
    chk("R1 strobes", {ch_wr_stb, ch_dis_stb, ch_cfg_stb, ch_en_stb}, 32'd0);
    do_read(12'h030, 4'hF);
    do_read(12'h034, 4'hF);
    // R2 R3 R5 R6 write sweep over the low byte (control word handled apart)
    for (int o = 0; o < 256; o += 4)
      if (o != 'h30) do_write(12'(o), 32'h1000_0000 + 32'(o * 3), 4'hF);
    // R4 R5 R6 read sweep
    for (int o = 0; o < 256; o += 4) do_read(12'(o), 4'hF);
    // R6 upper bit, R7 misaligned and partial
    do_read(12'h130, 4'hF);
    do_write(12'h140, 32'hDEAD_BEEF, 4'hF);
    do_write(12'h041, 32'h1234_5678, 4'hF);
    do_write(12'h034, 32'hFFFF_0000, 4'h3);
    do_write(12'h000, 32'h5555_5555, 4'h7);
    do_read(12'h036, 4'hF);
    do_read(12'h034, 4'hF);
    do_read(12'h034, 4'hE);
    // R8-R12 control sequencing
    ctrl_test(32'h0000_0000);
    ctrl_test(32'h1111_1111);
    ctrl_test(32'hFFFF_FFFF);
    ctrl_test(32'h6666_6666);
    ctrl_test(32'h8888_8888);
    ctrl_test(32'hA5C3_961E);
    ctrl_test(32'h5A3C_69E1);
    ctrl_test(32'h5A3C_69E1);
    ctrl_test(32'h0000_0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule